// File: doc/BRIEF.md
# Pixel Common-Stop Arrival-Time and Charge Digitizer

This block is the digital part of one pixel in a gaseous-detector readout array. When the discriminator of the pixel goes high, a fine counter starts. It runs on the fast clock and stops at the next slow-clock boundary. A coarse counter then counts slow-clock periods until a trigger that all pixels share ends the measurement. Because of this, the arrival time is measured back from the trigger. At the same time, a third counter counts how many slow-clock periods the discriminator stays above threshold, which gives a measure of the charge.

All three counters are shift-register counters with nonlinear feedback. Each one covers every state of its width, so a step costs one XOR tree instead of a carry chain. When the readout mode is selected, the same flip-flops, together with a hit flag and an overflow flag, form one serial chain. That chain is clocked out MSB first and passes a token on when it is done. The slow clock is given as a one-cycle `slow_tick` pulse that is synchronous to the fast clock `clk`. A six-bit configuration word is loaded serially. It holds a mask bit and the threshold trim value for the pixel.

Top module: `pix_cs_digitizer`

## Requirements
- R1: After reset, all counters, both flags and the configuration word are zero. `dout` reads 0, `tok_out` is 0, `trim` is 0, and an immediate readout returns 26 zero bits.
- R2: An input is sampled on each clock edge. The first edge that sees `disc` high after `disc` was low sets the hit flag and starts the fine counter. This applies only while the pixel is idle, unmasked and not in readout mode.
- R3: The fine counter steps once on every clock edge after the hit edge, up to the first edge that carries `slow_tick`. That edge does not step it, so the count is 0 to 15.
- R4: The coarse counter steps on every `slow_tick` edge after the fine stop until the trigger. A `trig` on the same edge as a `slow_tick` wins, and no step is taken.
- R5: The coarse counter holds at its last state after 4095 steps. The next `slow_tick` before the trigger sets the overflow flag.
- R6: A `trig` edge ends the measurement in any phase, and the pixel then stays closed. A trigger before any hit leaves the hit flag at 0. A trigger on the same edge as a rising `disc` suppresses the hit.
- R7: The ToT counter steps on each `slow_tick` edge after the hit edge while `disc` is still high. It stops for good at the first edge that sees `disc` low, and it holds at its last state after 255 steps.
- R8: Only one hit is recorded per reset. Later `disc` pulses change no field of the frame.
- R9: While `cfg_shift` is high outside readout, each edge shifts `ro_din` into the 6-bit word from the LSB side, so six shifts load it MSB first. Bit 5 is the mask and bits 4:0 drive `trim`. A masked pixel records no hit.
- R10: Every counter starts at zero and steps as s <= {s[W-2:0], f}, where f = XOR(s & TAPS) ^ (s[W-2:0]==0). TAPS is 4'hC for fine, 8'hB8 for ToT and 12'h829 for coarse. After 15 steps the fine counter reads 4'b1000.
- R11: While `ro_mode` is high, the measurement is frozen. `dout` shows the chain head, and each edge with `ro_shift` and `tok_in` both high shifts the chain by one bit. The 26-bit frame order is: hit, overflow, ToT[7:0], coarse[11:0], fine[3:0]. `ro_din` enters at fine bit 0.
- R12: `tok_out` goes high once 26 shifts have been made in readout mode. Shift requests made while `tok_in` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one fine bin per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse marking a slow-clock edge |
| disc | input | 1 | Discriminator output |
| trig | input | 1 | Shared common-stop trigger |
| cfg_shift | input | 1 | Shift `ro_din` into the configuration word |
| ro_mode | input | 1 | Readout mode: counters become one shift chain |
| ro_shift | input | 1 | Shift request for the readout chain |
| tok_in | input | 1 | Readout token from the previous pixel |
| ro_din | input | 1 | Serial data in (chain tail and configuration) |
| dout | output | 1 | Serial data out, chain head |
| tok_out | output | 1 | Token to the next pixel, high after a full frame |
| trim | output | 5 | Threshold trim bits for the front end |

## Verification
On every cycle, the assertions check the following: the fine count is frozen outside its window, the coarse and ToT counters hold once they saturate, the overflow flag and the closed state are sticky, the hit flag rises only from an unmasked discriminator sample, and the token rises only on a shift. The exact step counts depend on the phase of the hit relative to the slow tick, on trigger-versus-tick and trigger-versus-hit ties, on pulse lengths, on masking and on ignored second pulses. These counts, and the serial order of the frame, can only be shown by the bench's scenarios, which compare read-out frames against a per-edge reference model.

// File: rtl/pix_cs_pkg.sv
package pix_cs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FINE   = 2'd1,
    PH_COARSE = 2'd2,
    PH_DONE   = 2'd3
  } phase_e;

  localparam logic [3:0]  FINE_TAPS_DEF   = 4'hC;
  localparam logic [7:0]  TOT_TAPS_DEF    = 8'hB8;
  localparam logic [11:0] COARSE_TAPS_DEF = 12'h829;
endpackage

// File: rtl/pix_rst_sync.sv
module pix_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/pix_nlfsr.sv
module pix_nlfsr #(
  parameter int         W    = 4,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  logic         fb;
  logic [W-1:0] q_d;

  // zero-state insertion makes the sequence cover all 2**W states
  assign fb = (^(q & TAPS)) ^ (q[W-2:0] == '0);

  always_comb begin
    q_d = q;
    if (shift_en)  q_d = {q[W-2:0], shift_in};
    else if (step) q_d = {q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pix_cs_digitizer.sv
module pix_cs_digitizer #(
  parameter int FINE_W   = 4,
  parameter int COARSE_W = 12,
  parameter int TOT_W    = 8,
  parameter int TRIM_W   = 5,
  parameter logic [FINE_W-1:0]   FINE_TAPS   = pix_cs_pkg::FINE_TAPS_DEF,
  parameter logic [COARSE_W-1:0] COARSE_TAPS = pix_cs_pkg::COARSE_TAPS_DEF,
  parameter logic [TOT_W-1:0]    TOT_TAPS    = pix_cs_pkg::TOT_TAPS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              disc,
  input  logic              trig,
  input  logic              cfg_shift,
  input  logic              ro_mode,
  input  logic              ro_shift,
  input  logic              tok_in,
  input  logic              ro_din,
  output logic              dout,
  output logic              tok_out,
  output logic [TRIM_W-1:0] trim
);
  import pix_cs_pkg::*;

  localparam int CFG_W   = TRIM_W + 1;
  localparam int FRAME_W = 2 + TOT_W + COARSE_W + FINE_W;
  localparam int SCNT_W  = $clog2(FRAME_W + 1);
  localparam logic [SCNT_W-1:0]   SCNT_FULL  = SCNT_W'(FRAME_W);
  localparam logic [COARSE_W-1:0] COARSE_END = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [TOT_W-1:0]    TOT_END    = {1'b1, {(TOT_W-1){1'b0}}};

  logic rst_n_s;
  phase_e phase_q, phase_d;
  logic hit_q, hit_d, ovf_q, ovf_d, run_q, run_d, disc_q;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic shift_en, rise_ok, mask;
  logic fine_step, coarse_step, tot_step, coarse_end, tot_end;
  logic [FINE_W-1:0]   fine_q;
  logic [COARSE_W-1:0] coarse_q;
  logic [TOT_W-1:0]    tot_q;

  pix_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_n_s));

  pix_nlfsr #(.W(FINE_W), .TAPS(FINE_TAPS)) u_fine (
    .clk(clk), .rst_n(rst_n_s), .step(fine_step), .shift_en(shift_en),
    .shift_in(ro_din), .q(fine_q));

  pix_nlfsr #(.W(COARSE_W), .TAPS(COARSE_TAPS)) u_coarse (
    .clk(clk), .rst_n(rst_n_s), .step(coarse_step), .shift_en(shift_en),
    .shift_in(fine_q[FINE_W-1]), .q(coarse_q));

  pix_nlfsr #(.W(TOT_W), .TAPS(TOT_TAPS)) u_tot (
    .clk(clk), .rst_n(rst_n_s), .step(tot_step), .shift_en(shift_en),
    .shift_in(coarse_q[COARSE_W-1]), .q(tot_q));

  assign mask       = cfg_q[CFG_W-1];
  assign trim       = cfg_q[TRIM_W-1:0];
  assign coarse_end = (coarse_q == COARSE_END);
  assign tot_end    = (tot_q == TOT_END);
  assign shift_en   = ro_mode & ro_shift & tok_in;
  assign rise_ok    = disc & ~disc_q & ~mask & ~ro_mode & (phase_q == PH_IDLE);
  assign dout       = hit_q;
  assign tok_out    = ro_mode & (scnt_q == SCNT_FULL);

  always_comb begin
    phase_d     = phase_q;
    hit_d       = hit_q;
    ovf_d       = ovf_q;
    run_d       = run_q;
    cfg_d       = cfg_q;
    scnt_d      = scnt_q;
    fine_step   = 1'b0;
    coarse_step = 1'b0;
    tot_step    = 1'b0;
    if (shift_en) begin
      hit_d = ovf_q;
      ovf_d = tot_q[TOT_W-1];
    end else if (!ro_mode) begin
      case (phase_q)
        PH_IDLE: begin
          if (trig) phase_d = PH_DONE;
          else if (rise_ok) begin
            phase_d = PH_FINE;
            hit_d   = 1'b1;
            run_d   = 1'b1;
          end
        end
        PH_FINE: begin
          if (trig)           phase_d = PH_DONE;
          else if (slow_tick) phase_d = PH_COARSE;
          else                fine_step = 1'b1;
        end
        PH_COARSE: begin
          if (trig) phase_d = PH_DONE;
          else if (slow_tick) begin
            if (coarse_end) ovf_d = 1'b1;
            else            coarse_step = 1'b1;
          end
        end
        default: ;
      endcase
      if (run_q) begin
        if (!disc)                       run_d    = 1'b0;
        else if (slow_tick && !tot_end)  tot_step = 1'b1;
      end
    end
    if (cfg_shift && !ro_mode) cfg_d = {cfg_q[CFG_W-2:0], ro_din};
    if (!ro_mode)                            scnt_d = '0;
    else if (shift_en && scnt_q != SCNT_FULL) scnt_d = scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q <= PH_IDLE;
      hit_q   <= 1'b0;
      ovf_q   <= 1'b0;
      run_q   <= 1'b0;
      disc_q  <= 1'b0;
      cfg_q   <= '0;
      scnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      hit_q   <= hit_d;
      ovf_q   <= ovf_d;
      run_q   <= run_d;
      disc_q  <= disc;
      cfg_q   <= cfg_d;
      scnt_q  <= scnt_d;
    end
  end

  p_fine_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q != PH_FINE && !ro_mode) |=> $stable(fine_q));
  p_coarse_sat_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (coarse_end && !ro_mode) |=> coarse_end);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovf_q && !ro_mode) |=> ovf_q);
  p_closed_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q == PH_DONE) |=> (phase_q == PH_DONE));
  p_tot_sat_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tot_end && !ro_mode) |=> tot_end);
  p_one_hit_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit_q && !ro_mode) |=> (phase_q != PH_IDLE));
  p_hit_src_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(hit_q) && !$past(ro_mode)) |-> $past(disc && !mask));
  p_tok_rise_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tok_out) |-> $past(shift_en));
endmodule

// File: tb/pix_cs_digitizer_tb_top.sv
`timescale 1ns/1ps
module pix_cs_digitizer_tb_top;
  localparam int FW = 4, CW = 12, TW = 8, FRW = 26, TICK = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, slow_tick, disc, trig, cfg_shift, ro_mode, ro_shift, tok_in, ro_din;
  logic dout, tok_out;
  logic [4:0] trim;

  pix_cs_digitizer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .disc(disc), .trig(trig),
    .cfg_shift(cfg_shift), .ro_mode(ro_mode), .ro_shift(ro_shift), .tok_in(tok_in),
    .ro_din(ro_din), .dout(dout), .tok_out(tok_out), .trim(trim));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int ph, nf, nc, nt;
  bit mh, movf, mrun, mdq, mmask;

  function automatic logic [31:0] walk(int w, logic [31:0] taps, int n);
    logic [31:0] s = 0, lowm, allm;
    logic fb;
    lowm = (32'd1 << (w - 1)) - 1;
    allm = (32'd1 << w) - 1;
    for (int i = 0; i < n; i++) begin
      fb = (^(s & taps)) ^ ((s & lowm) == 0);
      s  = ((s << 1) | 32'(fb)) & allm;
    end
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc_(bit d, bit tr);
    bit tk, rise;
    @(negedge clk);
    tk = ((cyc % TICK) == TICK - 1);
    disc = d; trig = tr; slow_tick = tk;
    cyc++;
    rise = d && !mdq && !mmask && ph == 0;
    if (mrun) begin
      if (!d) mrun = 0;
      else if (tk && nt < (1 << TW) - 1) nt++;
    end
    case (ph)
      0: if (tr) ph = 3; else if (rise) begin ph = 1; mh = 1; mrun = 1; end
      1: if (tr) ph = 3; else if (tk) ph = 2; else nf++;
      2: if (tr) ph = 3; else if (tk) begin
           if (nc == (1 << CW) - 1) movf = 1; else nc++;
         end
      default: ;
    endcase
    mdq = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; disc = 0; trig = 0; slow_tick = 0; cfg_shift = 0;
    ro_mode = 0; ro_shift = 0; tok_in = 1; ro_din = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    ph = 0; nf = 0; nc = 0; nt = 0; mh = 0; movf = 0; mrun = 0; mdq = 0; mmask = 0;
    repeat (3) cyc_(0, 0);
  endtask

  task automatic load_cfg(logic [5:0] v);
    for (int i = 5; i >= 0; i--) begin
      @(negedge clk);
      slow_tick = 0; cfg_shift = 1; ro_din = v[i];
    end
    @(negedge clk);
    cfg_shift = 0; ro_din = 0;
    mmask = v[5];
  endtask

  task automatic read_frame(output logic [FRW-1:0] w, output logic tp, output logic tq);
    @(negedge clk);
    disc = 0; trig = 0; slow_tick = 0; ro_mode = 1; tok_in = 1; ro_shift = 0;
    for (int i = 0; i < FRW; i++) begin
      @(negedge clk);
      w[FRW-1-i] = dout;
      if (i == FRW - 1) tp = tok_out;
      ro_shift = 1;
    end
    @(negedge clk);
    ro_shift = 0; tq = tok_out;
    @(negedge clk);
    ro_mode = 0;
    mdq = 0;
  endtask

  task automatic verify();
    logic [FRW-1:0] w;
    logic tp, tq;
    read_frame(w, tp, tq);
    chk("R2 R6 R8 R11 hit flag", 32'(w[25]), 32'(mh));
    chk("R5 overflow flag", 32'(w[24]), 32'(movf));
    chk("R7 tot field", 32'(w[23:16]), walk(TW, 32'hB8, nt));
    chk("R4 coarse field", 32'(w[15:4]), walk(CW, 32'h829, nc));
    chk("R3 fine field", 32'(w[3:0]), walk(FW, 32'hC, nf));
    chk("R12 token low before last shift", 32'(tp), 0);
    chk("R12 token high after frame", 32'(tq), 1);
  endtask

  task automatic trial(int pre, int plen, int tdly, bit second, bit use_cfg, logic [5:0] cv);
    int len;
    do_reset();
    if (use_cfg) begin
      load_cfg(cv);
      chk("R9 trim output", 32'(trim), 32'(cv[4:0]));
    end
    repeat (pre) cyc_(0, 0);
    len = ((plen > tdly) ? plen : tdly) + 8;
    for (int i = 0; i < len; i++)
      cyc_((i < plen) || (second && i >= plen + 2 && i < plen + 6), i == tdly);
    verify();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FRW-1:0] w;
    logic tp, tq;
    void'($urandom(32'd20240611));
    rst_n = 0; disc = 0; trig = 0; slow_tick = 0; cfg_shift = 0;
    ro_mode = 0; ro_shift = 0; tok_in = 1; ro_din = 0;

    // R1 reset state
    do_reset();
    chk("R1 dout after reset", 32'(dout), 0);
    chk("R1 tok_out after reset", 32'(tok_out), 0);
    chk("R1 trim after reset", 32'(trim), 0);
    read_frame(w, tp, tq);
    chk("R1 empty frame", 32'(w), 0);

    // R3 R10 hit on a tick edge: fine runs the full 15 steps
    do_reset();
    while ((cyc % TICK) != TICK - 1) cyc_(0, 0);
    cyc_(1, 0);
    repeat (40) cyc_(1, 0);
    repeat (20) cyc_(0, 0);
    cyc_(0, 1);
    read_frame(w, tp, tq);
    chk("R10 fine code after 15 steps", 32'(w[3:0]), 32'h8);
    chk("R3 fine steps on tick-aligned hit", 32'(w[3:0]), walk(FW, 32'hC, nf));

    // R6 trigger before any hit closes the pixel
    do_reset();
    cyc_(0, 1);
    repeat (5) cyc_(0, 0);
    repeat (30) cyc_(1, 0);
    verify();

    // R6 trigger on the same edge as the hit
    trial(7, 20, 0, 0, 0, 6'd0);

    // R9 masked pixel
    trial(3, 50, 200, 0, 1, 6'b1_10110);

    // R12 shifts ignored without token, frame intact afterwards
    do_reset();
    repeat (9) cyc_(0, 0);
    repeat (70) cyc_(1, 0);
    repeat (60) cyc_(0, 0);
    cyc_(0, 1);
    @(negedge clk);
    disc = 0; slow_tick = 0; ro_mode = 1; tok_in = 0; ro_shift = 1;
    repeat (30) begin
      @(negedge clk);
      chk("R12 dout frozen while token low", 32'(dout), 32'(mh));
    end
    chk("R12 no token without tok_in", 32'(tok_out), 0);
    ro_shift = 0; tok_in = 1;
    verify();

    // R5 R7 coarse overflow and ToT saturation
    do_reset();
    repeat (5) cyc_(0, 0);
    for (int i = 0; i < 66000; i++) cyc_(i < 4200, 0);
    verify();

    // R8 random trials, some with a later pulse, some masked
    for (int t = 0; t < 24; t++) begin
      int pre, plen, tdly;
      bit sec, uc;
      logic [5:0] cv;
      pre  = $urandom_range(0, 40);
      plen = $urandom_range(1, 200);
      tdly = $urandom_range(0, 600);
      sec  = 1'($urandom_range(0, 1));
      uc   = ($urandom_range(0, 3) == 0);
      cv   = 6'($urandom_range(0, 63));
      trial(pre, plen, tdly, sec, uc, cv);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule